// File: doc/BRIEF.md
# Adaptive Offload Ratio Controller

This block chooses what share of offloadable code-block instances is shipped to a near-memory execution unit instead of running on the local core. It counts instructions retired over fixed-length epochs. At the end of each epoch it compares that count with the one from the previous epoch and moves a fixed-point offload ratio with a hill-climbing search whose step adapts. The step starts large. It is halved while the search keeps reversing direction. It snaps back to its initial size when the retired count jumps sharply, which marks a program phase change.

Each offloadable instance that reaches the block carries two estimates. One is the cache-locality benefit of running it remotely. The other is the cost of moving its registers. An instance whose benefit is below its cost always stays local. Every other instance is thinned to the current ratio by an overflow accumulator, so offloads are spread evenly through the stream and do not arrive in bursts.

The retired-instruction count, the benefit estimate and the cost estimate are produced outside the block. The block returns the current ratio and, one cycle after each instance, a decision for that instance.

Top module: `offload_ratio_ctrl`

## Requirements
- R1: After a synchronous reset the ratio equals RATIO_INIT (default 128, meaning 0.5), the step equals STEP_INIT (default 32), the search direction is upward, no previous epoch is on record, and dec_valid is 0.
- R2: An epoch is EPOCH_CYC cycles long (default 16). Its score is the sum of retire_cnt over those cycles. The ratio changes only at the clock edge that closes an epoch, so the new value is visible from the next cycle, and during the epoch's last cycle the old value is still shown.
- R3: If the score is at least the previous epoch's score, the direction is kept. If it is lower, the direction is reversed before the move. The first epoch after reset has no comparison and moves in the current direction.
- R4: The ratio is unsigned with FRAC_W fraction bits, and 1.0 is 2^FRAC_W (default 256). It saturates at 0 and at 1.0. A move that reaches either bound leaves the direction pointing away from that bound for the next epoch. Such a bound reversal does not count as a score-driven reversal for R5.
- R5: When a score-driven reversal happens in two consecutive epochs, the step is halved before the move, but it never goes below 1.
- R6: When the score differs from the previous score by more than PHASE_THR (default 48), the step is reset to STEP_INIT before the move. This takes priority over halving.
- R7: For each instance that is eligible, the ratio is added to an accumulator. The instance is offloaded when the sum reaches 1.0, and 1.0 is then subtracted. With a ratio of 0.5 and a cleared accumulator, eligible instances alternate between not offloaded and offloaded, starting with not offloaded. A ratio of 0 never offloads.
- R8: An instance with inst_benefit < inst_cost is never offloaded and leaves the accumulator unchanged. An instance with equal benefit and cost is eligible.
- R9: dec_valid is 1 exactly in the cycle after a cycle with inst_valid = 1. dec_offload carries that instance's decision (1 = run remotely).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_cnt | input | RET_W | Instructions retired in this cycle |
| inst_valid | input | 1 | An offloadable instance asks for a decision |
| inst_benefit | input | COST_W | Estimated benefit of offloading this instance |
| inst_cost | input | COST_W | Estimated register-transfer cost of this instance |
| offload_ratio | output | FRAC_W+1 | Current offload ratio, 2^FRAC_W meaning 1.0 |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_offload | output | 1 | 1 = offload the instance, 0 = run it locally |

## Verification
The bench drives a long run of epochs whose scores first climb and then wander. This pushes the ratio into the upper bound several times, through chains of consecutive reversals until the step reaches 1, and through sudden jumps in the score. A design that counted a bound reversal as an oscillation, let the step reach 0, or halved the step on a phase jump would show a different ratio within one or two epochs. A design that reacted one cycle late would fail the last-cycle check. The decision stream is tested at a ratio of 0.5 with vetoed and tied instances mixed in, and again at a ratio of 0. This catches an accumulator that advances on vetoed instances, a veto that rejects ties, and stray offloads at a zero ratio.

// File: rtl/ofr_pkg.sv
package ofr_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } climb_dir_e;

  // Halve a step, keeping at least one LSB.
  function automatic logic [15:0] halve_floor1(input logic [15:0] s);
    logic [15:0] h;
    h = s >> 1;
    return (h == 16'd0) ? 16'd1 : h;
  endfunction

endpackage

// File: rtl/ofr_epoch_sampler.sv
module ofr_epoch_sampler #(
  parameter int EPOCH_CYC = 16,
  parameter int RET_W     = 3,
  parameter int SUM_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RET_W-1:0] retire_cnt,
  output logic             epoch_end,
  output logic [SUM_W-1:0] epoch_sum
);
  localparam int CNT_W = (EPOCH_CYC > 2) ? $clog2(EPOCH_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCH_CYC - 1);

  logic [CNT_W-1:0] cyc_q;
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_nx;

  // Score including the current cycle's retirements.
  assign acc_nx    = acc_q + SUM_W'(retire_cnt);
  assign epoch_end = (cyc_q == LAST);
  assign epoch_sum = acc_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else if (epoch_end) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      acc_q <= acc_nx;
    end
  end

  // R2: epoch counter wraps back to zero after the closing cycle
  a_r2_epoch_wrap: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> (cyc_q == '0));

  // R2: counter never passes the epoch length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cyc_q <= LAST);

endmodule

// File: rtl/ofr_hill_climber.sv
module ofr_hill_climber
  import ofr_pkg::*;
#(
  parameter int FRAC_W     = 8,
  parameter int SUM_W      = 8,
  parameter int STEP_INIT  = 32,
  parameter int RATIO_INIT = 128,
  parameter int PHASE_THR  = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             epoch_end,
  input  logic [SUM_W-1:0] epoch_sum,
  output logic [FRAC_W:0]  ratio
);
  localparam int RW = FRAC_W + 1;
  localparam logic [RW-1:0]    ONE   = RW'(1) << FRAC_W;
  localparam logic [RW-1:0]    S_INI = RW'(STEP_INIT);
  localparam logic [RW-1:0]    R_INI = RW'(RATIO_INIT);
  localparam logic [SUM_W-1:0] THR   = SUM_W'(PHASE_THR);

  logic [RW-1:0]    ratio_q;
  logic [RW-1:0]    step_q;
  climb_dir_e       dir_q;
  logic [SUM_W-1:0] prev_q;
  logic             have_prev_q;
  logic             flip_q;

  logic             dropped;
  logic             phase_jump;
  logic [SUM_W-1:0] diff;
  climb_dir_e       dir_eff;
  logic [RW-1:0]    step_half;
  logic [RW-1:0]    step_nx;
  logic [RW:0]      up_sum;
  logic [RW-1:0]    ratio_nx;
  logic             hit_bound;

  always_comb begin
    dropped    = have_prev_q && (epoch_sum < prev_q);
    diff       = (epoch_sum >= prev_q) ? (epoch_sum - prev_q) : (prev_q - epoch_sum);
    phase_jump = have_prev_q && (diff > THR);
    dir_eff    = dropped ? ((dir_q == DIR_UP) ? DIR_DOWN : DIR_UP) : dir_q;
    step_half  = RW'(halve_floor1(16'(step_q)));

    if (phase_jump)             step_nx = S_INI;
    else if (dropped && flip_q) step_nx = step_half;
    else                        step_nx = step_q;

    up_sum = {1'b0, ratio_q} + {1'b0, step_nx};
    if (dir_eff == DIR_UP) begin
      hit_bound = (up_sum >= {1'b0, ONE});
      ratio_nx  = hit_bound ? ONE : up_sum[RW-1:0];
    end else begin
      hit_bound = (step_nx >= ratio_q);
      ratio_nx  = hit_bound ? '0 : (ratio_q - step_nx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q     <= R_INI;
      step_q      <= S_INI;
      dir_q       <= DIR_UP;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      flip_q      <= 1'b0;
    end else if (epoch_end) begin
      ratio_q     <= ratio_nx;
      step_q      <= step_nx;
      dir_q       <= hit_bound ? ((dir_eff == DIR_UP) ? DIR_DOWN : DIR_UP) : dir_eff;
      prev_q      <= epoch_sum;
      have_prev_q <= 1'b1;
      flip_q      <= dropped;
    end
  end

  assign ratio = ratio_q;

  // R4: ratio never exceeds 1.0
  a_r4_ratio_le_one: assert property (@(posedge clk) disable iff (rst)
    ratio_q <= ONE);

  // R5: step stays in [1, STEP_INIT]
  a_r5_step_range: assert property (@(posedge clk) disable iff (rst)
    (step_q >= RW'(1)) && (step_q <= S_INI));

  // R2: ratio and step only move at an epoch boundary
  a_r2_hold_in_epoch: assert property (@(posedge clk) disable iff (rst)
    !epoch_end |=> ($stable(ratio_q) && $stable(step_q)));

  // R5/R6: a step only stays, halves or returns to its initial size
  a_r6_step_moves: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> ((step_q == $past(step_q)) || (step_q == S_INI) ||
                   (step_q == ($past(step_q) >> 1)) || (step_q == RW'(1))));

endmodule

// File: rtl/ofr_offload_gate.sv
module ofr_offload_gate #(
  parameter int FRAC_W = 8,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W:0]   ratio,
  input  logic              inst_valid,
  input  logic [COST_W-1:0] inst_benefit,
  input  logic [COST_W-1:0] inst_cost,
  output logic              dec_valid,
  output logic              dec_offload
);
  localparam int RW = FRAC_W + 1;
  localparam logic [RW:0] ONE_X = (RW + 1)'(1) << FRAC_W;

  logic [RW-1:0] acc_q;
  logic          eligible;
  logic [RW:0]   acc_sum;
  logic          overflow;

  assign eligible = (inst_benefit >= inst_cost);
  assign acc_sum  = {1'b0, acc_q} + {1'b0, ratio};
  assign overflow = (acc_sum >= ONE_X);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      dec_valid   <= 1'b0;
      dec_offload <= 1'b0;
    end else begin
      dec_valid   <= inst_valid;
      dec_offload <= inst_valid && eligible && overflow;
      if (inst_valid && eligible) begin
        acc_q <= overflow ? RW'(acc_sum - ONE_X) : acc_sum[RW-1:0];
      end
    end
  end

  // R7: accumulator stays below 1.0
  a_r7_acc_below_one: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc_q} < ONE_X);

  // R8: vetoed instance yields a local decision
  a_r8_veto: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && (inst_benefit < inst_cost)) |=> (dec_valid && !dec_offload));

  // R7: zero ratio never offloads
  a_r7_zero_ratio: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && (ratio == '0)) |=> !dec_offload);

  // R9: decision follows a request by exactly one cycle
  a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
    inst_valid |=> dec_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inst_valid |=> !dec_valid);

endmodule

// File: rtl/offload_ratio_ctrl.sv
module offload_ratio_ctrl #(
  parameter int FRAC_W     = 8,
  parameter int EPOCH_CYC  = 16,
  parameter int RET_W      = 3,
  parameter int COST_W     = 8,
  parameter int STEP_INIT  = 32,
  parameter int RATIO_INIT = 128,
  parameter int PHASE_THR  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RET_W-1:0]  retire_cnt,
  input  logic              inst_valid,
  input  logic [COST_W-1:0] inst_benefit,
  input  logic [COST_W-1:0] inst_cost,
  output logic [FRAC_W:0]   offload_ratio,
  output logic              dec_valid,
  output logic              dec_offload
);
  localparam int SUM_W = RET_W + $clog2(EPOCH_CYC) + 1;

  logic             epoch_end;
  logic [SUM_W-1:0] epoch_sum;
  logic [FRAC_W:0]  ratio_w;

  ofr_epoch_sampler #(
    .EPOCH_CYC (EPOCH_CYC),
    .RET_W     (RET_W),
    .SUM_W     (SUM_W)
  ) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .retire_cnt (retire_cnt),
    .epoch_end  (epoch_end),
    .epoch_sum  (epoch_sum)
  );

  ofr_hill_climber #(
    .FRAC_W     (FRAC_W),
    .SUM_W      (SUM_W),
    .STEP_INIT  (STEP_INIT),
    .RATIO_INIT (RATIO_INIT),
    .PHASE_THR  (PHASE_THR)
  ) u_climber (
    .clk       (clk),
    .rst       (rst),
    .epoch_end (epoch_end),
    .epoch_sum (epoch_sum),
    .ratio     (ratio_w)
  );

  ofr_offload_gate #(
    .FRAC_W (FRAC_W),
    .COST_W (COST_W)
  ) u_gate (
    .clk          (clk),
    .rst          (rst),
    .ratio        (ratio_w),
    .inst_valid   (inst_valid),
    .inst_benefit (inst_benefit),
    .inst_cost    (inst_cost),
    .dec_valid    (dec_valid),
    .dec_offload  (dec_offload)
  );

  assign offload_ratio = ratio_w;

endmodule

// File: tb/test_offload_ratio_ctrl.sv
module test_offload_ratio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EPOCH      = 16;
  localparam int NVEC       = 30;

  // Retired-per-cycle value for each epoch (score = value * 16) and the
  // ratio expected right after that epoch closes, worked out by hand
  // from R3, R4, R5 and R6.
  localparam int VEC_RET [NVEC] = '{2,3,3,3,3,2,1,1,0,7,6,5,4,5,5,4,3,2,1,0,0,
                                    7,7,7,7,7,7,7,7,7};
  localparam int VEC_EXP [NVEC] = '{160,192,224,256,224,256,256,240,256,224,256,
                                    256,256,248,240,248,244,246,245,246,247,
                                    256,224,192,160,128,96,64,32,0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] retire_cnt = '0;
  logic       inst_valid = 1'b0;
  logic [7:0] inst_benefit = '0;
  logic [7:0] inst_cost = '0;
  logic [8:0] offload_ratio;
  logic       dec_valid;
  logic       dec_offload;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  offload_ratio_ctrl i_offload_ratio_ctrl (
    .clk          (clk),
    .rst          (rst),
    .retire_cnt   (retire_cnt),
    .inst_valid   (inst_valid),
    .inst_benefit (inst_benefit),
    .inst_cost    (inst_cost),
    .offload_ratio(offload_ratio),
    .dec_valid    (dec_valid),
    .dec_offload  (dec_offload)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instance at a negedge, observe its decision at the next.
  task automatic instance_step(input bit v, input int ben, input int cost,
                               input bit exp_off, input string req);
    inst_valid   = v;
    inst_benefit = 8'(ben);
    inst_cost    = 8'(cost);
    @(negedge clk);
    check(dec_valid == v, {req, " dec_valid"}, int'(dec_valid), int'(v));
    check(dec_offload == exp_off, {req, " dec_offload"}, int'(dec_offload), int'(exp_off));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    inst_valid = 1'b0;
    retire_cnt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    check(offload_ratio == 9'd128, "R1 ratio after reset", int'(offload_ratio), 128);
    check(dec_valid == 1'b0, "R1 dec_valid after reset", int'(dec_valid), 0);

    // R7/R8/R9 at ratio 0.5, within the first epoch
    instance_step(1'b1, 10, 5, 1'b0, "R7 first half");
    instance_step(1'b1, 10, 5, 1'b1, "R7 overflow");
    instance_step(1'b1, 3, 5, 1'b0, "R8 veto");
    instance_step(1'b1, 10, 5, 1'b0, "R8 veto left acc unchanged");
    instance_step(1'b1, 5, 5, 1'b1, "R8 tie eligible");
    instance_step(1'b0, 0, 0, 1'b0, "R9 idle");
    instance_step(1'b1, 200, 0, 1'b0, "R7 alternate a");
    instance_step(1'b1, 200, 0, 1'b1, "R7 alternate b");
    inst_valid = 1'b0;
    check(offload_ratio == 9'd128, "R2 ratio held mid-epoch", int'(offload_ratio), 128);

    // Epoch table walk from a fresh reset
    do_reset();
    for (int e = 0; e < NVEC; e++) begin
      int prev_exp;
      prev_exp = (e == 0) ? 128 : VEC_EXP[e-1];
      for (int c = 0; c < EPOCH; c++) begin
        retire_cnt = 3'(VEC_RET[e]);
        if (c == EPOCH - 1)
          check(offload_ratio == 9'(prev_exp), "R2 old ratio in last cycle",
                int'(offload_ratio), prev_exp);
        @(negedge clk);
      end
      check(offload_ratio == 9'(VEC_EXP[e]), "R3 R4 R5 R6 epoch ratio",
            int'(offload_ratio), VEC_EXP[e]);
    end

    // R7: ratio now 0, eligible instances stay local
    retire_cnt = '0;
    instance_step(1'b1, 9, 1, 1'b0, "R7 zero ratio a");
    instance_step(1'b1, 9, 1, 1'b0, "R7 zero ratio b");
    instance_step(1'b1, 9, 9, 1'b0, "R7 zero ratio c");
    inst_valid = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule